// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This block is the integer multiply datapath of a processor execute stage. An opcode picks one of seven operations: unsigned or signed 32x32 products that give a 64-bit result split into a low and a high destination word, each with an optional 64-bit accumulate; signed 16x16 halfword products whose halves are picked by two select bits, with an optional 32-bit accumulate; and a signed 32x16 word-by-halfword product that keeps the middle 32 bits. The pipeline supplies the operands, the accumulator words, the current condition flags and the current saturation bit. The block returns the destination words, the updated flags and the updated saturation bit.

Each result goes into one output register behind a valid/ready handshake. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears at the outputs on the next cycle and is held until the consumer takes it. The register file, instruction decode and clearing of the saturation bit are handled by the rest of the pipeline.

Top module: `imac_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid`=0, `dst_lo`=`dst_hi`=0, `flags_out`=0 and `q_out`=0. `in_ready` is 1 while `out_valid` is 0.
- R2: Opcode encoding: 0 unsigned long multiply, 1 unsigned long multiply-accumulate, 2 signed long multiply, 3 signed long multiply-accumulate, 4 halfword multiply, 5 halfword multiply-accumulate, 6 word-by-halfword multiply, 7 unused. The unsigned long forms zero-extend both operands. The 64-bit result goes out with bits 31:0 on `dst_lo` and bits 63:32 on `dst_hi`.
- R3: The signed long forms sign-extend both 32-bit operands to 64 bits before they multiply.
- R4: The long accumulate forms (opcodes 1 and 3) add the 64-bit value {`acc_hi`,`acc_lo`} to the product, modulo 2^64.
- R5: The flag bits are N=bit 3, Z=bit 2, C=bit 1 and V=bit 0. A long form with `set_flags`=1 sets N to result bit 63 and sets Z only when all 64 result bits are zero. C and V keep their input values. With `set_flags`=0, `flags_out` equals `flags_in`.
- R6: In the halfword forms, a select bit of 1 takes bits 31:16 of its operand and 0 takes bits 15:0 (`sel_hi_a` for `opnd_a`, `sel_hi_b` for `opnd_b`). Each half is sign-extended before the multiply. `dst_hi` is 0 for all 32-bit-result forms.
- R7: The halfword multiply-accumulate adds `acc_lo` to the 32-bit product. When that signed addition overflows, `q_out` is 1. `flags_out` equals `flags_in` whatever `set_flags` holds.
- R8: The saturation bit is sticky: `q_out` is 1 whenever `q_in` is 1, and in every other case equals `q_in` unless R7 sets it.
- R9: The halfword multiply and the word-by-halfword multiply pass `flags_in` and `q_in` through unchanged.
- R10: The word-by-halfword form multiplies the signed 32-bit `opnd_a` by the sign-extended half of `opnd_b` that `sel_hi_b` picks, and returns product bits 47:16.
- R11: `in_ready` = !`out_valid` | `out_ready`. An accepted operation's result is on the outputs in the next cycle. While `out_valid`=1 and `out_ready`=0, the outputs hold and no new operation is accepted.
- R12: Opcode 7 gives `dst_lo`=`dst_hi`=0 and passes the flags and the saturation bit through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op | input | 3 | Operation code (R2) |
| set_flags | input | 1 | Long forms update N and Z |
| sel_hi_a | input | 1 | Upper half of `opnd_a` for halfword forms |
| sel_hi_b | input | 1 | Upper half of `opnd_b` for halfword forms |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| acc_hi | input | 32 | High accumulator word (long forms) |
| acc_lo | input | 32 | Low accumulator word / halfword accumulator |
| flags_in | input | 4 | Current NZCV |
| q_in | input | 1 | Current saturation bit |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result present |
| dst_lo | output | 32 | Low destination word |
| dst_hi | output | 32 | High destination word |
| flags_out | output | 4 | Updated NZCV |
| q_out | output | 1 | Updated saturation bit |

## Verification
The only state in the block is the output register, so a fault in it appears at the ports on the cycle right after acceptance. A loss of the stall hold would show as `dst_lo` changing while `out_ready` is low. A wrong extension or half selection shows as a wrong high word or a wrong sign one cycle after the operation. For that reason the vectors use 0x80000000, 0x7FFFFFFF, 0x8000 and all-ones operands. A wrong flag or saturation path shows as N or Z differing from the 64-bit reference, or as C, V or Q changing where they must pass through. The checks also cover overflow of the halfword accumulate in both directions and a pass with Q already set.

// File: rtl/imac_pkg.sv
package imac_pkg;
  typedef enum logic [2:0] {
    OP_UMUL  = 3'd0,
    OP_UMAC  = 3'd1,
    OP_SMUL  = 3'd2,
    OP_SMAC  = 3'd3,
    OP_HMUL  = 3'd4,
    OP_HMAC  = 3'd5,
    OP_WHMUL = 3'd6,
    OP_RSVD  = 3'd7
  } imac_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_long(imac_op_e o);
    return (o == OP_UMUL) || (o == OP_UMAC) || (o == OP_SMUL) || (o == OP_SMAC);
  endfunction
endpackage

// File: rtl/imac_opsel.sv
// Operand extension: picks halves and widens both multiplicands to 2*W bits.
module imac_opsel
  import imac_pkg::*;
#(
  parameter int W = 32
) (
  input  imac_op_e         op,
  input  logic             sel_hi_a,
  input  logic             sel_hi_b,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-1:0]   ma,
  output logic [2*W-1:0]   mb
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [1:0][W-1:0]  src;
  logic [1:0]         sel;
  logic [1:0][DW-1:0] half_sx;
  logic [1:0][DW-1:0] word_sx;
  logic [1:0][DW-1:0] word_zx;

  assign src = {b, a};
  assign sel = {sel_hi_b, sel_hi_a};

  // Same widening logic for both operands
  for (genvar g = 0; g < 2; g++) begin : g_ext
    logic [H-1:0] half;
    assign half       = sel[g] ? src[g][W-1:H] : src[g][H-1:0];
    assign half_sx[g] = {{(DW-H){half[H-1]}}, half};
    assign word_sx[g] = {{W{src[g][W-1]}}, src[g]};
    assign word_zx[g] = {{W{1'b0}}, src[g]};
  end

  always_comb begin
    ma = '0;
    mb = '0;
    unique case (op)
      OP_UMUL, OP_UMAC: begin ma = word_zx[0]; mb = word_zx[1]; end
      OP_SMUL, OP_SMAC: begin ma = word_sx[0]; mb = word_sx[1]; end
      OP_HMUL, OP_HMAC: begin ma = half_sx[0]; mb = half_sx[1]; end
      OP_WHMUL:         begin ma = word_sx[0]; mb = half_sx[1]; end
      default:          begin ma = '0;         mb = '0;         end
    endcase
  end
endmodule

// File: rtl/imac_arith.sv
// Multiply, accumulate, result formatting and flag/saturation update.
module imac_arith
  import imac_pkg::*;
#(
  parameter int W = 32
) (
  input  imac_op_e        op,
  input  logic            set_flags,
  input  logic [2*W-1:0]  ma,
  input  logic [2*W-1:0]  mb,
  input  logic [W-1:0]    acc_hi,
  input  logic [W-1:0]    acc_lo,
  input  nzcv_t           flags_in,
  input  logic            q_in,
  output logic [W-1:0]    res_lo,
  output logic [W-1:0]    res_hi,
  output nzcv_t           flags_out,
  output logic            q_out
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [DW-1:0] prod;
  logic [DW-1:0] long_add;
  logic [DW-1:0] long_res;
  logic [W-1:0]  half_sum;
  logic          half_ovf;

  assign prod     = ma * mb;
  assign long_add = ((op == OP_UMAC) || (op == OP_SMAC)) ? {acc_hi, acc_lo} : '0;
  assign long_res = prod + long_add;
  assign half_sum = prod[W-1:0] + acc_lo;
  assign half_ovf = (prod[W-1] == acc_lo[W-1]) && (half_sum[W-1] != prod[W-1]);

  always_comb begin
    res_lo    = '0;
    res_hi    = '0;
    flags_out = flags_in;
    q_out     = q_in;
    unique case (op)
      OP_UMUL, OP_UMAC, OP_SMUL, OP_SMAC: begin
        res_lo = long_res[W-1:0];
        res_hi = long_res[DW-1:W];
        if (set_flags) begin
          flags_out.n = long_res[DW-1];
          flags_out.z = (long_res == '0);
        end
      end
      OP_HMUL:  res_lo = prod[W-1:0];
      OP_HMAC: begin
        res_lo = half_sum;
        q_out  = q_in | half_ovf;
      end
      OP_WHMUL: res_lo = prod[W+H-1:H];
      default: begin
        res_lo = '0;
        res_hi = '0;
      end
    endcase
  end
endmodule

// File: rtl/imac_outreg.sv
// One-entry result register with valid/ready handshake.
module imac_outreg #(
  parameter int W = 32,
  parameter int F = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  input  logic [W-1:0]  d_lo,
  input  logic [W-1:0]  d_hi,
  input  logic [F-1:0]  d_flags,
  input  logic          d_q,
  output logic          out_valid,
  output logic [W-1:0]  q_lo,
  output logic [W-1:0]  q_hi,
  output logic [F-1:0]  q_flags,
  output logic          q_sat
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_lo      <= '0;
      q_hi      <= '0;
      q_flags   <= '0;
      q_sat     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      q_lo      <= d_lo;
      q_hi      <= d_hi;
      q_flags   <= d_flags;
      q_sat     <= d_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: a stalled result stays valid and unchanged
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_lo) && $stable(q_hi) && $stable(q_flags)));

  // R11: an accepted operation is visible on the next cycle
  a_r11_accept_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/imac_unit.sv
module imac_unit
  import imac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic          set_flags,
  input  logic          sel_hi_a,
  input  logic          sel_hi_b,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [W-1:0]  acc_hi,
  input  logic [W-1:0]  acc_lo,
  input  logic [3:0]    flags_in,
  input  logic          q_in,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  dst_lo,
  output logic [W-1:0]  dst_hi,
  output logic [3:0]    flags_out,
  output logic          q_out
);
  localparam int DW = 2 * W;

  imac_op_e      op_e;
  logic [DW-1:0] ma, mb;
  logic [W-1:0]  r_lo, r_hi;
  nzcv_t         r_flags;
  logic          r_q;
  logic          fire;

  assign op_e = imac_op_e'(op);
  assign fire = in_valid && in_ready;

  imac_opsel #(.W(W)) u_opsel (
    .op(op_e), .sel_hi_a(sel_hi_a), .sel_hi_b(sel_hi_b),
    .a(opnd_a), .b(opnd_b), .ma(ma), .mb(mb)
  );

  imac_arith #(.W(W)) u_arith (
    .op(op_e), .set_flags(set_flags), .ma(ma), .mb(mb),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .flags_in(nzcv_t'(flags_in)), .q_in(q_in),
    .res_lo(r_lo), .res_hi(r_hi), .flags_out(r_flags), .q_out(r_q)
  );

  imac_outreg #(.W(W), .F(4)) u_outreg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .d_lo(r_lo), .d_hi(r_hi), .d_flags(r_flags), .d_q(r_q),
    .out_valid(out_valid), .q_lo(dst_lo), .q_hi(dst_hi), .q_flags(flags_out), .q_sat(q_out)
  );

  // R5: long forms never touch C and V
  a_r5_cv_kept: assert property (@(posedge clk) disable iff (rst)
    (fire && is_long(op_e)) |=> (flags_out[1:0] == $past(flags_in[1:0])));

  // R8: saturation is never cleared here
  a_r8_q_sticky: assert property (@(posedge clk) disable iff (rst)
    (fire && q_in) |=> q_out);

  // R9: plain halfword and word-by-halfword keep all status
  a_r9_no_status_change: assert property (@(posedge clk) disable iff (rst)
    (fire && (op_e == OP_HMUL || op_e == OP_WHMUL))
      |=> (flags_out == $past(flags_in) && q_out == $past(q_in)));

  // R6: 32-bit-result forms leave the high word zero
  a_r6_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (fire && !is_long(op_e)) |=> (dst_hi == '0));
endmodule

// File: tb/imac_unit_tb_top.sv
`timescale 1ns/1ps
module imac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, set_flags, sel_hi_a, sel_hi_b, q_in, out_ready;
  logic [2:0]  op;
  logic [31:0] opnd_a, opnd_b, acc_hi, acc_lo, dst_lo, dst_hi;
  logic [3:0]  flags_in, flags_out;
  logic        out_valid, q_out;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  imac_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .set_flags(set_flags), .sel_hi_a(sel_hi_a), .sel_hi_b(sel_hi_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .flags_in(flags_in), .q_in(q_in), .out_ready(out_ready), .out_valid(out_valid),
    .dst_lo(dst_lo), .dst_hi(dst_hi), .flags_out(flags_out), .q_out(q_out)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        sa;
    logic        sb;
    logic        sf;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ah;
    logic [31:0] al;
    logic [3:0]  fl;
    logic        q;
  } vec_t;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [3:0]  fl;
    logic        q;
  } exp_t;

  localparam int NV = 18;
  // op, sel_a, sel_b, set_flags, a, b, acc_hi, acc_lo, flags, q
  localparam vec_t VECS [NV] = '{
    '{3'd0,1'b0,1'b0,1'b1,32'hFFFFFFFF,32'hFFFFFFFF,32'h0,32'h0,4'b0011,1'b0},
    '{3'd0,1'b0,1'b0,1'b1,32'h00000000,32'h12345678,32'h0,32'h0,4'b1000,1'b0},
    '{3'd1,1'b0,1'b0,1'b1,32'h80000000,32'h00000002,32'h1,32'hFFFFFFFF,4'b0010,1'b0},
    '{3'd2,1'b0,1'b0,1'b1,32'h80000000,32'h7FFFFFFF,32'h0,32'h0,4'b0001,1'b0},
    '{3'd2,1'b0,1'b0,1'b0,32'hFFFFFFFF,32'h00000003,32'h0,32'h0,4'b1010,1'b0},
    '{3'd3,1'b0,1'b0,1'b1,32'hFFFFFFFF,32'h00000001,32'h0,32'h1,4'b1011,1'b0},
    '{3'd3,1'b0,1'b0,1'b1,32'h80000000,32'h80000000,32'hFFFFFFFF,32'hFFFFFFFF,4'b0100,1'b0},
    '{3'd4,1'b0,1'b0,1'b1,32'h00018000,32'h80000003,32'h0,32'h0,4'b0101,1'b0},
    '{3'd4,1'b1,1'b1,1'b0,32'h80001234,32'h7FFF0000,32'h0,32'h0,4'b0000,1'b0},
    '{3'd4,1'b1,1'b0,1'b0,32'h7FFF0000,32'h00007FFF,32'h0,32'h0,4'b1100,1'b1},
    '{3'd5,1'b0,1'b1,1'b1,32'h00008000,32'h80000000,32'h0,32'h7FFFFFFF,4'b0011,1'b0},
    '{3'd5,1'b0,1'b0,1'b0,32'h00000002,32'h00000003,32'h0,32'h5,4'b0000,1'b1},
    '{3'd5,1'b1,1'b1,1'b0,32'h80000000,32'h7FFF0000,32'h0,32'h80000000,4'b1001,1'b0},
    '{3'd5,1'b0,1'b0,1'b0,32'h00000004,32'h0000FFFF,32'h0,32'h00000010,4'b0000,1'b0},
    '{3'd6,1'b0,1'b0,1'b0,32'h80000000,32'h00007FFF,32'h0,32'h0,4'b0110,1'b0},
    '{3'd6,1'b0,1'b1,1'b0,32'h7FFFFFFF,32'h80000000,32'h0,32'h0,4'b0000,1'b1},
    '{3'd6,1'b0,1'b0,1'b0,32'h12345678,32'h0000FFFF,32'h0,32'h0,4'b1111,1'b0},
    '{3'd7,1'b0,1'b0,1'b1,32'h12345678,32'h9ABCDEF0,32'h5,32'h6,4'b1111,1'b1}
  };

  // Reference model from the requirements, in 64-bit arithmetic
  function automatic exp_t model(vec_t v);
    exp_t        e;
    logic [63:0] u;
    longint      s;
    logic signed [15:0] ha, hb;
    e.lo = '0; e.hi = '0; e.fl = v.fl; e.q = v.q;
    ha = v.sa ? v.a[31:16] : v.a[15:0];
    hb = v.sb ? v.b[31:16] : v.b[15:0];
    case (v.op)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        if (v.op < 3'd2) u = {32'h0, v.a} * {32'h0, v.b};
        else             u = 64'(longint'($signed(v.a)) * longint'($signed(v.b)));
        if (v.op == 3'd1 || v.op == 3'd3) u = u + {v.ah, v.al};
        e.lo = u[31:0];
        e.hi = u[63:32];
        if (v.sf) begin
          e.fl[3] = u[63];
          e.fl[2] = (u == 64'h0);
        end
      end
      3'd4: begin
        s = longint'(ha) * longint'(hb);
        e.lo = s[31:0];
      end
      3'd5: begin
        s = longint'(ha) * longint'(hb) + longint'($signed(v.al));
        e.lo = s[31:0];
        if (s > 64'sh7FFFFFFF || s < -64'sh80000000) e.q = 1'b1;
      end
      3'd6: begin
        s = longint'($signed(v.a)) * longint'(hb);
        e.lo = s[47:16];
      end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic drive(vec_t v);
    op = v.op; sel_hi_a = v.sa; sel_hi_b = v.sb; set_flags = v.sf;
    opnd_a = v.a; opnd_b = v.b; acc_hi = v.ah; acc_lo = v.al;
    flags_in = v.fl; q_in = v.q;
  endtask

  task automatic run_vec(vec_t v);
    exp_t  e;
    string ft;
    e = model(v);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    ft = (v.op < 3'd4) ? "R5" : ((v.op == 3'd5) ? "R7" : ((v.op == 3'd7) ? "R12" : "R9"));
    chk("R11", "out_valid", {31'h0, out_valid}, 32'h1);
    chk(tag_of(v.op), "dst_lo", dst_lo, e.lo);
    chk(tag_of(v.op), "dst_hi", dst_hi, e.hi);
    chk(ft, "flags_out", {28'h0, flags_out}, {28'h0, e.fl});
    chk("R8", "q_out", {31'h0, q_out}, {31'h0, e.q});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t eb;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    drive(VECS[0]);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1", "dst_lo", dst_lo, 32'h0);
    chk("R1", "dst_hi", dst_hi, 32'h0);
    chk("R1", "flags_out", {28'h0, flags_out}, 32'h0);
    chk("R1", "in_ready", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    rst = 1'b0;

    // Vector table: R2..R10, R12
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: stall holds result and refuses a new operation
    run_vec(VECS[0]);
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[3]);
    in_valid = 1'b1;
    #0.5;
    chk("R11", "in_ready stalled", {31'h0, in_ready}, 32'h0);
    @(posedge clk);
    #1;
    chk("R11", "held dst_lo", dst_lo, 32'h00000001);
    chk("R11", "held dst_hi", dst_hi, 32'hFFFFFFFE);
    chk("R11", "held out_valid", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    eb = model(VECS[3]);
    chk("R11", "next dst_lo", dst_lo, eb.lo);
    chk("R11", "next dst_hi", dst_hi, eb.hi);
    @(posedge clk);
    #1;
    chk("R11", "drain out_valid", {31'h0, out_valid}, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule